// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Feedback Divider

This block sits in the feedback path of a frequency synthesizer, behind an external dual-modulus prescaler that divides the oscillator by P or by P+1. Each time the prescaler completes one of its periods, the block receives a single-cycle `pre_tick` strobe. The block runs two down-counters from these strobes. The swallow count A tracks how many prescaler periods must still use the long modulus. The main count B counts every prescaler period of one output cycle. While the swallow count is nonzero, the block asks the prescaler for P+1, and after that it asks for P. An output cycle therefore lasts A·(P+1) + (B−A)·P = B·P + A oscillator cycles, so the ratio can be set in steps of one while the prescaler itself stays coarse.

The block logic is clocked by the oscillator-rate clock `clk`, and `pre_tick` acts as a clock enable. The prescaler period is taken from a 2-bit code. New A, B and P values are sampled only at the counter load point, which is the end of an output cycle, a synchronous restart, or reset. Software can therefore rewrite the values at any time without producing a truncated cycle. A restart input forces the load point, so the phase detector sees its first edge one full ratio after the restart. A flag reports settings for which the ratio formula does not hold.

Top module: `pswallow_div`

## Requirements
- R1: With A on the 6-bit `a_val`, B on the 13-bit `b_val` (1 ≤ B, A ≤ B) and modulus P, rising edges of `div_pulse` are exactly B·P + A `clk` cycles apart.
- R2: `p_sel` selects P: 2'b00 gives 8, 2'b01 gives 16, 2'b10 gives 32 and 2'b11 gives 64. `mod_div` always shows the period being requested, which is P+1 while `mod_hi` is 1 and P while `mod_hi` is 0.
- R3: Within each output cycle, `mod_hi` is 1 for the first A prescaler periods and 0 for the remaining B−A periods, so that it stays high for A·(P+1) `clk` cycles per output cycle.
- R4: When `sync_rst` is sampled high, both counters load the current inputs. The next `div_pulse` then appears B·P + A cycles after that edge, and `sync_rst` suppresses any pulse in the cycle it is sampled.
- R5: Changes to `a_val`, `b_val` or `p_sel` during a count leave the current output cycle unchanged. The new values set the cycle that follows the next load point.
- R6: `cfg_err` is 1 when the loaded values have B < A or B = 0, and 0 otherwise. It changes only at a load point.
- R7: `div_pulse` is high for exactly one `clk` cycle per output cycle.
- R8: While `rst` is high, the block holds its load point. The outputs then show `div_pulse` = 0, `mod_hi` = 1 exactly when `a_val` is nonzero, `mod_div` according to R2, and `cfg_err` according to R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator-rate clock |
| rst | input | 1 | Synchronous active-high reset; holds the load point |
| sync_rst | input | 1 | Synchronous restart to the load point, used for phase alignment |
| pre_tick | input | 1 | One-cycle strobe at the end of each prescaler period |
| a_val | input | 6 | Swallow count A |
| b_val | input | 13 | Main count B |
| p_sel | input | 2 | Prescaler modulus code |
| mod_hi | output | 1 | Request for P+1 (1) or P (0) |
| mod_div | output | 7 | Prescaler period currently requested |
| div_pulse | output | 1 | One-cycle pulse per output cycle |
| cfg_err | output | 1 | Loaded values violate B ≥ A, B ≥ 1 |

## Verification
The hardest behaviour to reach from the ports is the loop between the block and the prescaler. The period of every prescaler cycle depends on `mod_hi` just after the previous tick. Wrong steering therefore shows up only as a drift in the spacing of output pulses. To expose it, the bench contains a behavioural prescaler that reloads its period from `mod_hi` on the cycle after each tick. The bench then measures the restart latency, the pulse spacing and the time `mod_hi` spends high. It does this for tabled and random settings, including A = 0, A = B and the case where every period is long. A mid-count rewrite, a change from a legal to an illegal setting, and a tick that arrives together with the restart are placed relative to observed pulses.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;

  localparam int unsigned PSEL_W    = 2;
  localparam int unsigned BASE_LOG2 = 3;
  localparam int unsigned MOD_MAX   = (1 << (BASE_LOG2 + (1 << PSEL_W) - 1)) + 1;

  typedef enum logic [PSEL_W-1:0] {
    PSEL_8  = 2'b00,
    PSEL_16 = 2'b01,
    PSEL_32 = 2'b10,
    PSEL_64 = 2'b11
  } psel_e;

  function automatic int unsigned base_modulus(input logic [PSEL_W-1:0] code);
    return (32'd1 << BASE_LOG2) << code;
  endfunction

endpackage

// File: rtl/pswallow_main_cnt.sv
module pswallow_main_cnt #(
  parameter int unsigned W = 13
) (
  input  logic         clk,
  input  logic         load,
  input  logic         tick,
  input  logic [W-1:0] val,
  output logic         last
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (load) begin
      cnt_q <= val;
    end else if (tick) begin
      cnt_q <= cnt_q - W'(1);
    end
  end

  // a count of one (or an illegal zero) ends the output cycle on the next tick
  assign last = (cnt_q <= W'(1));

endmodule

// File: rtl/pswallow_swallow_cnt.sv
module pswallow_swallow_cnt #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         load,
  input  logic         tick,
  input  logic [W-1:0] val,
  output logic         busy_nxt
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = val;
    end else if (tick && (cnt_q != '0)) begin
      cnt_d = cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk) begin
    cnt_q <= cnt_d;
  end

  // look-ahead so the registered request is valid right after the tick edge
  assign busy_nxt = |cnt_d;

endmodule

// File: rtl/pswallow_mod_sel.sv
module pswallow_mod_sel
  import pswallow_pkg::*;
#(
  parameter int unsigned M_W = 7
) (
  input  logic              clk,
  input  logic              load,
  input  logic [PSEL_W-1:0] p_sel,
  input  logic              busy_nxt,
  output logic              mod_hi,
  output logic [M_W-1:0]    mod_div
);

  logic [PSEL_W-1:0] code_q;
  logic [PSEL_W-1:0] code_nxt;
  logic [M_W-1:0]    base_nxt;

  always_comb begin
    code_nxt = load ? p_sel : code_q;
    base_nxt = M_W'(base_modulus(code_nxt));
  end

  always_ff @(posedge clk) begin
    code_q  <= code_nxt;
    mod_hi  <= busy_nxt;
    mod_div <= busy_nxt ? (base_nxt + M_W'(1)) : base_nxt;
  end

endmodule

// File: rtl/pswallow_div.sv
module pswallow_div
  import pswallow_pkg::*;
#(
  parameter int unsigned A_W = 6,
  parameter int unsigned B_W = 13,
  parameter int unsigned M_W = $clog2(MOD_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_rst,
  input  logic              pre_tick,
  input  logic [A_W-1:0]    a_val,
  input  logic [B_W-1:0]    b_val,
  input  logic [PSEL_W-1:0] p_sel,
  output logic              mod_hi,
  output logic [M_W-1:0]    mod_div,
  output logic              div_pulse,
  output logic              cfg_err
);

  localparam int unsigned CMP_W = (A_W > B_W) ? A_W : B_W;

  logic b_last;
  logic wrap;
  logic load;
  logic busy_nxt;

  assign wrap = pre_tick & b_last & ~rst & ~sync_rst;
  assign load = rst | sync_rst | (pre_tick & b_last);

  pswallow_main_cnt #(.W(B_W)) main_i (
    .clk  (clk),
    .load (load),
    .tick (pre_tick),
    .val  (b_val),
    .last (b_last)
  );

  pswallow_swallow_cnt #(.W(A_W)) swal_i (
    .clk      (clk),
    .load     (load),
    .tick     (pre_tick),
    .val      (a_val),
    .busy_nxt (busy_nxt)
  );

  pswallow_mod_sel #(.M_W(M_W)) msel_i (
    .clk      (clk),
    .load     (load),
    .p_sel    (p_sel),
    .busy_nxt (busy_nxt),
    .mod_hi   (mod_hi),
    .mod_div  (mod_div)
  );

  always_ff @(posedge clk) begin
    div_pulse <= wrap;
    if (load) begin
      cfg_err <= (CMP_W'(b_val) < CMP_W'(a_val)) | (b_val == '0);
    end
  end

endmodule

// File: rtl/pswallow_div_chk.sv
module pswallow_div_chk #(
  parameter int unsigned M_W = 7
) (
  input logic           clk,
  input logic           rst,
  input logic           sync_rst,
  input logic           pre_tick,
  input logic           mod_hi,
  input logic [M_W-1:0] mod_div,
  input logic           div_pulse,
  input logic           cfg_err
);

  AST_PULSE_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
    div_pulse |-> ($past(pre_tick) && !$past(sync_rst))) else $error("pulse without tick"); // R4

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    div_pulse |=> !div_pulse) else $error("pulse wider than one cycle"); // R7

  AST_MOD_PARITY: assert property (@(posedge clk) disable iff (rst)
    mod_div[0] == mod_hi) else $error("period does not match request"); // R2

  AST_MOD_FALL_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    $fell(mod_hi) |-> ($past(pre_tick) || $past(sync_rst) || $past(rst))) else $error("request dropped between ticks"); // R3

  AST_PERIOD_HELD: assert property (@(posedge clk) disable iff (rst)
    (!$past(pre_tick) && !$past(sync_rst) && !$past(rst)) |-> $stable(mod_div)) else $error("period moved between ticks"); // R5

  AST_CFG_AT_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!$past(pre_tick) && !$past(sync_rst) && !$past(rst)) |-> $stable(cfg_err)) else $error("flag moved off load point"); // R6

endmodule

bind pswallow_div pswallow_div_chk #(.M_W(M_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .sync_rst  (sync_rst),
  .pre_tick  (pre_tick),
  .mod_hi    (mod_hi),
  .mod_div   (mod_div),
  .div_pulse (div_pulse),
  .cfg_err   (cfg_err)
);

// File: tb/pswallow_div_tb_top.sv
`timescale 1ns/1ps
module pswallow_div_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sync_rst = 1'b0;
  logic        pre_tick = 1'b0;
  logic [5:0]  a_val = 6'd4;
  logic [12:0] b_val = 13'd6;
  logic [1:0]  p_sel = 2'b00;
  logic        mod_hi;
  logic [6:0]  mod_div;
  logic        div_pulse;
  logic        cfg_err;

  always #2 clk = ~clk;

  pswallow_div dut_i (
    .clk(clk), .rst(rst), .sync_rst(sync_rst), .pre_tick(pre_tick),
    .a_val(a_val), .b_val(b_val), .p_sel(p_sel),
    .mod_hi(mod_hi), .mod_div(mod_div), .div_pulse(div_pulse), .cfg_err(cfg_err)
  );

  // a, b, p code, expected ratio
  localparam int VEC [8][4] = '{
    '{0, 3, 0, 24}, '{5, 7, 0, 61}, '{3, 4, 1, 67}, '{63, 63, 0, 567},
    '{1, 1, 2, 33}, '{10, 20, 3, 1290}, '{0, 1, 1, 16}, '{7, 9, 2, 295}
  };

  int total = 0, bad = 0;
  int cyc = 0, rem = 0, tb_p = 8;
  int pulse_cnt = 0, last_pulse = 0, hi_acc = 0, hi_snap = 0;
  int md_err = 0, wide_err = 0;
  bit md_en = 0, prev_pulse = 0, done = 0;

  // behavioural prescaler and output monitor
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst) begin
      rem = 0;
      pre_tick = 1'b0;
    end else begin
      if (sync_rst) rem = 0;
      if (rem == 0) rem = mod_hi ? tb_p + 1 : tb_p;
      pre_tick = (rem == 1);
      rem = rem - 1;
    end
    if (div_pulse) begin
      pulse_cnt = pulse_cnt + 1;
      last_pulse = cyc;
      hi_snap = hi_acc;
      hi_acc = mod_hi ? 1 : 0;
    end else begin
      hi_acc = hi_acc + (mod_hi ? 1 : 0);
    end
    if (div_pulse && prev_pulse) wide_err = wide_err + 1;
    prev_pulse = div_pulse;
    if (md_en && !rst && (int'(mod_div) != tb_p + (mod_hi ? 1 : 0))) md_err = md_err + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_pulse(output int at);
    int start = pulse_cnt;
    int guard = 0;
    while (pulse_cnt == start && guard < 6000) begin
      @(negedge clk); #1;
      guard++;
    end
    if (pulse_cnt == start) begin
      chk(0, "R1 pulse timeout", 0, 1);
      at = cyc;
    end else begin
      at = last_pulse;
    end
  endtask

  task automatic restart(input int a, input int b, input int code, output int c0);
    md_en = 0;
    @(negedge clk); #1;
    a_val = 6'(a); b_val = 13'(b); p_sel = 2'(code); tb_p = 8 << code;
    sync_rst = 1'b1;
    c0 = cyc;
    @(negedge clk); #1;
    sync_rst = 1'b0;
    md_err = 0;
    md_en = 1;
  endtask

  task automatic run_setting(input int a, input int b, input int code, input int n);
    int c0, t1, t2, p;
    p = 8 << code;
    restart(a, b, code, c0);
    wait_pulse(t1);
    chk(t1 - c0 == n + 1, "R4 restart latency", t1 - c0, n + 1);
    wait_pulse(t2);
    chk(t2 - t1 == n, "R1 period", t2 - t1, n);
    chk(hi_snap == a * (p + 1), "R3 long-modulus time", hi_snap, a * (p + 1));
    chk(md_err == 0, "R2 modulus value", md_err, 0);
    chk(cfg_err == 1'b0, "R6 legal setting", cfg_err, 0);
  endtask

  initial begin
    int c0, t0, t1, t2, t3;
    // R8: reset state with a=4 b=6 p=8
    repeat (3) @(negedge clk);
    #1;
    chk(div_pulse == 1'b0, "R8 pulse in reset", div_pulse, 0);
    chk(mod_hi == 1'b1, "R8 request in reset", mod_hi, 1);
    chk(mod_div == 7'd9, "R8 period in reset", mod_div, 9);
    chk(cfg_err == 1'b0, "R8 flag in reset", cfg_err, 0);
    rst = 1'b0;

    for (int i = 0; i < 8; i++) begin
      run_setting(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3]);
    end

    // R1 with random legal settings
    for (int k = 0; k < 6; k++) begin
      int b = 1 + int'($urandom % 40);
      int a = int'($urandom % (b + 1));
      int code = int'($urandom % 4);
      run_setting(a, b, code, b * (8 << code) + a);
    end

    // R5: rewrite during a count, P kept at 8
    restart(0, 3, 0, c0);
    md_en = 0;
    wait_pulse(t0);
    repeat (3) @(negedge clk);
    #1;
    a_val = 6'd2; b_val = 13'd5;
    wait_pulse(t1);
    chk(t1 - t0 == 24, "R5 old ratio kept", t1 - t0, 24);
    wait_pulse(t2);
    chk(t2 - t1 == 42, "R5 new ratio after load", t2 - t1, 42);
    // R6: illegal values written mid-count flag only at the load point
    repeat (3) @(negedge clk);
    #1;
    a_val = 6'd9; b_val = 13'd4;
    repeat (3) @(negedge clk);
    #1;
    chk(cfg_err == 1'b0, "R6 flag waits for load", cfg_err, 0);
    wait_pulse(t3);
    chk(cfg_err == 1'b1, "R6 flag at load (B<A)", cfg_err, 1);

    // R6 via restart: B < A and B = 0
    restart(5, 2, 0, c0);
    md_en = 0;
    chk(cfg_err == 1'b1, "R6 B<A", cfg_err, 1);
    restart(0, 0, 0, c0);
    md_en = 0;
    chk(cfg_err == 1'b1, "R6 B=0", cfg_err, 1);
    restart(0, 2, 0, c0);
    md_en = 0;
    chk(cfg_err == 1'b0, "R6 cleared by legal load", cfg_err, 0);

    // R4: restart lands on the tick that would have ended the cycle
    wait_pulse(t0);
    repeat (14) @(negedge clk);
    #1;
    sync_rst = 1'b1;
    c0 = cyc;
    @(negedge clk); #1;
    sync_rst = 1'b0;
    repeat (4) @(negedge clk);
    #1;
    chk(pulse_cnt == 1 + pulse_cnt - 1 && div_pulse == 1'b0, "R4 no pulse on restart", div_pulse, 0);
    wait_pulse(t1);
    chk(t1 - c0 == 17, "R4 latency after restart", t1 - c0, 17);

    chk(wide_err == 0, "R7 one-cycle pulse", wide_err, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule